// File: doc/BRIEF.md
# Post-Increment Load Datapath

This block is a single-cycle 32-bit load datapath. Each clock cycle it fetches one instruction from an internal instruction array at the program counter, decodes it, and commits the result at the following rising edge. It executes two instructions. The first is a plain word load. The second is a post-increment load. In the same cycle, the post-increment load reads a word at base plus a signed 12-bit offset into the destination register, and it writes the base plus 4 back into the base register.

To do both writes at once, the register file has two write ports, each with its own enable. The first port carries the load result. The second carries the output of a dedicated +4 adder fed from the first read port, and it is addressed directly by the base-register field.

The instruction and data arrays are filled through a simple load port, normally while reset is held. A third read port of the register file lets the surrounding logic observe architectural register state. The decoder outputs are also brought out as ports.

Top module: `pinc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes 0 and no register is written.
- R2: With `rst` low, the PC increases by 4 at every rising edge. The instruction executed is the array word at index PC[7:2].
- R3: A word load is identified by opcode bits[6:0]=0000011 and funct3 bits[14:12]=010. It writes rd (bits[11:7]) with the data word at rs1 (bits[19:15]) plus the sign-extended bits[31:20]. rs1 is left unchanged, and `dec_wen2` is 0.
- R4: A post-increment load is identified by opcode 0001011 and funct3 010. It writes rd with the loaded word and writes rs1 with the old rs1 plus 4, both at the same edge. While it executes, `dec_wen1`, `dec_wen2` and `dec_mrd` are 1 and `dec_mwe` is 0.
- R5: The 12-bit offset is sign-extended, so negative offsets address below the base.
- R6: If a post-increment load has rd equal to rs1, the register ends up holding the loaded word, not the incremented base.
- R7: A write to register 0 on either port is discarded, and register 0 always reads as zero.
- R8: Address bits [1:0] are ignored. The data word is selected by address bits [9:2].
- R9: Any other opcode, or either load opcode with funct3 other than 010, deasserts all four enables, and no register changes.
- R10: Register reads are combinational, so an instruction sees a value written by the instruction in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Load-port write strobe |
| ld_sel | input | 1 | Load-port target: 0 instruction array, 1 data array |
| ld_addr | input | 8 | Load-port word index |
| ld_data | input | 32 | Load-port write word |
| pc_o | output | 32 | Current program counter |
| dbg_idx | input | 5 | Register observation index |
| dbg_val | output | 32 | Value of the observed register |
| dec_wen1 | output | 1 | Decoder: first write-port enable |
| dec_wen2 | output | 1 | Decoder: second (increment) write-port enable |
| dec_mrd | output | 1 | Decoder: data read enable |
| dec_mwe | output | 1 | Decoder: data write enable |

## Verification
Both register writes of an instruction land at the rising edge that ends its cycle. An instruction placed at array index k is therefore committed by the k+1-th edge after reset is released.

The bench releases reset on a falling edge and counts falling edges to let exactly the program length of instructions run. It then re-asserts reset, so that nothing further commits, before reading registers through the observation port.

Decoder outputs are combinational from the fetched word. They are sampled on the falling edge inside the cycle in which that instruction's PC is current. The PC is sampled on falling edges, where it equals four times the number of edges seen since reset was released.

// File: rtl/pinc_pkg.sv
package pinc_pkg;
  localparam logic [6:0] OPC_LOAD = 7'b0000011;
  localparam logic [6:0] OPC_LINC = 7'b0001011;
  localparam logic [2:0] F3_WORD  = 3'b010;

  typedef enum logic [1:0] {
    ALU_ADD   = 2'b00,
    ALU_SUB   = 2'b01,
    ALU_PASSB = 2'b10
  } alu_op_e;

  typedef struct packed {
    logic    alu_src;
    alu_op_e alu_op;
    logic    mem_to_reg;
    logic    reg_we1;
    logic    mem_rd;
    logic    mem_we;
    logic    reg_we2;
  } ctl_t;
endpackage

// File: rtl/pinc_ctrl.sv
module pinc_ctrl
  import pinc_pkg::*;
(
  input  logic [6:0] opcode,
  input  logic [2:0] funct3,
  output ctl_t       ctl
);
  always_comb begin
    ctl = '{alu_src: 1'b0, alu_op: ALU_ADD, mem_to_reg: 1'b0, reg_we1: 1'b0,
            mem_rd: 1'b0, mem_we: 1'b0, reg_we2: 1'b0};
    if (funct3 == F3_WORD) begin
      unique case (opcode)
        OPC_LOAD: begin
          ctl.alu_src    = 1'b1;
          ctl.mem_to_reg = 1'b1;
          ctl.reg_we1    = 1'b1;
          ctl.mem_rd     = 1'b1;
        end
        OPC_LINC: begin
          ctl.alu_src    = 1'b1;
          ctl.mem_to_reg = 1'b1;
          ctl.reg_we1    = 1'b1;
          ctl.mem_rd     = 1'b1;
          ctl.reg_we2    = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pinc_alu.sv
module pinc_alu
  import pinc_pkg::*;
#(
  parameter int DW = 32
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_SUB:   y = a - b;
      ALU_PASSB: y = b;
      default:   y = a + b;
    endcase
  end
endmodule

// File: rtl/pinc_regfile.sv
module pinc_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic           clk,
  input  logic [RAW-1:0] ra1,
  output logic [DW-1:0]  rd1,
  input  logic [RAW-1:0] ra2,
  output logic [DW-1:0]  rd2,
  input  logic [RAW-1:0] ra3,
  output logic [DW-1:0]  rd3,
  input  logic           we1,
  input  logic [RAW-1:0] wa1,
  input  logic [DW-1:0]  wd1,
  input  logic           we2,
  input  logic [RAW-1:0] wa2,
  input  logic [DW-1:0]  wd2
);
  logic [DW-1:0] rf [NREG];

  // port 1 is written last so it wins a same-register collision
  always_ff @(posedge clk) begin
    if (we2 && wa2 != '0) rf[wa2] <= wd2;
    if (we1 && wa1 != '0) rf[wa1] <= wd1;
  end

  assign rd1 = (ra1 == '0) ? '0 : rf[ra1];
  assign rd2 = (ra2 == '0) ? '0 : rf[ra2];
  assign rd3 = (ra3 == '0) ? '0 : rf[ra3];

  // R6: load data wins over the increment on a shared target
  a_r6_port1_wins: assert property (@(posedge clk)
    (we1 && we2 && wa1 == wa2 && wa1 != '0) |=> rf[$past(wa1)] == $past(wd1));
  // R4: a lone second-port write lands
  a_r4_port2_lands: assert property (@(posedge clk)
    (we2 && wa2 != '0 && !(we1 && wa1 == wa2)) |=> rf[$past(wa2)] == $past(wd2));
  // R3: a first-port write lands
  a_r3_port1_lands: assert property (@(posedge clk)
    (we1 && wa1 != '0) |=> rf[$past(wa1)] == $past(wd1));
endmodule

// File: rtl/pinc_core.sv
module pinc_core
  import pinc_pkg::*;
#(
  parameter int DW     = 32,
  parameter int NREG   = 32,
  parameter int IDEPTH = 64,
  parameter int DDEPTH = 256,
  parameter int LDAW   = 8,
  parameter int INC    = 4,
  localparam int RAW   = $clog2(NREG),
  localparam int IAW   = $clog2(IDEPTH),
  localparam int DAW   = $clog2(DDEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_we,
  input  logic            ld_sel,
  input  logic [LDAW-1:0] ld_addr,
  input  logic [DW-1:0]   ld_data,
  output logic [DW-1:0]   pc_o,
  input  logic [RAW-1:0]  dbg_idx,
  output logic [DW-1:0]   dbg_val,
  output logic            dec_wen1,
  output logic            dec_wen2,
  output logic            dec_mrd,
  output logic            dec_mwe
);
  logic [DW-1:0] pc_q;
  logic [31:0]   imem [IDEPTH];
  logic [DW-1:0] dmem [DDEPTH];
  logic [31:0]   inst;
  ctl_t          ctl;
  logic [DW-1:0] rs1_val, rs2_val, imm_sx, alu_b, alu_y, mem_q, wb1_data, inc_val;

  // program counter
  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_q + DW'(4);
  end
  assign pc_o = pc_q;

  // instruction and data arrays, filled through the load port
  always_ff @(posedge clk) begin
    if (ld_we && !ld_sel) imem[ld_addr[IAW-1:0]] <= ld_data[31:0];
  end
  always_ff @(posedge clk) begin
    if (ld_we && ld_sel) dmem[ld_addr[DAW-1:0]] <= ld_data;
  end

  assign inst = imem[pc_q[IAW+1:2]];

  pinc_ctrl u_ctrl (
    .opcode (inst[6:0]),
    .funct3 (inst[14:12]),
    .ctl    (ctl)
  );

  assign imm_sx = {{(DW-12){inst[31]}}, inst[31:20]};
  assign alu_b  = ctl.alu_src ? imm_sx : rs2_val;

  pinc_alu #(.DW(DW)) u_alu (
    .op (ctl.alu_op),
    .a  (rs1_val),
    .b  (alu_b),
    .y  (alu_y)
  );

  // word access, byte offset bits dropped
  assign mem_q    = dmem[alu_y[DAW+1:2]];
  assign wb1_data = ctl.mem_to_reg ? mem_q : alu_y;
  assign inc_val  = rs1_val + DW'(INC);

  pinc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk (clk),
    .ra1 (inst[19:15]),
    .rd1 (rs1_val),
    .ra2 (inst[24:20]),
    .rd2 (rs2_val),
    .ra3 (dbg_idx),
    .rd3 (dbg_val),
    .we1 (ctl.reg_we1 && !rst),
    .wa1 (inst[11:7]),
    .wd1 (wb1_data),
    .we2 (ctl.reg_we2 && !rst),
    .wa2 (inst[19:15]),
    .wd2 (inc_val)
  );

  assign dec_wen1 = ctl.reg_we1;
  assign dec_wen2 = ctl.reg_we2;
  assign dec_mrd  = ctl.mem_rd;
  assign dec_mwe  = ctl.mem_we;

  a_r1_pc_clear: assert property (@(posedge clk) rst |=> pc_q == '0);
  a_r2_pc_step: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pc_q == $past(pc_q) + DW'(4));
  a_r4_ctl_pair: assert property (@(posedge clk) disable iff (rst)
    dec_wen2 |-> (dec_wen1 && dec_mrd && !dec_mwe));
  a_r9_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
    (inst[6:0] != OPC_LOAD && inst[6:0] != OPC_LINC)
      |-> !(dec_wen1 || dec_wen2 || dec_mrd || dec_mwe));
endmodule

// File: tb/pinc_core_tb.sv
module pinc_core_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_we = 1'b0;
  logic        ld_sel = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] pc_o;
  logic [4:0]  dbg_idx = '0;
  logic [31:0] dbg_val;
  logic        dec_wen1, dec_wen2, dec_mrd, dec_mwe;

  int checks = 0;
  int errors = 0;
  logic [31:0] prog [64];

  always #5 clk = ~clk;

  pinc_core u_dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_sel(ld_sel), .ld_addr(ld_addr),
    .ld_data(ld_data), .pc_o(pc_o), .dbg_idx(dbg_idx), .dbg_val(dbg_val),
    .dec_wen1(dec_wen1), .dec_wen2(dec_wen2), .dec_mrd(dec_mrd), .dec_mwe(dec_mwe)
  );

  function automatic logic [31:0] ld_w(int off, int rs1, int rd);
    return {12'(off), 5'(rs1), 3'b010, 5'(rd), 7'b0000011};
  endfunction
  function automatic logic [31:0] li_w(int off, int rs1, int rd);
    return {12'(off), 5'(rs1), 3'b010, 5'(rd), 7'b0001011};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic chk_reg(string tag, int idx, logic [31:0] exp);
    dbg_idx = 5'(idx);
    #1;
    chk(tag, dbg_val, exp);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) prog[i] = '0;
  endtask

  task automatic load_prog();
    rst = 1'b1;
    for (int i = 0; i < 64; i++) begin
      ld_we = 1'b1; ld_sel = 1'b0; ld_addr = 8'(i); ld_data = prog[i];
      @(negedge clk);
    end
    ld_we = 1'b0;
  endtask

  task automatic load_data();
    for (int i = 0; i < 16; i++) begin
      ld_we = 1'b1; ld_sel = 1'b1; ld_addr = 8'(i);
      ld_data = (i == 4) ? 32'h10 : (i == 8) ? 32'h20 : 32'hA000_0000 + 32'(i);
      @(negedge clk);
    end
    ld_we = 1'b0;
  endtask

  task automatic run(int n);
    rst = 1'b0;
    repeat (n) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_pc();
    clear_prog(); load_prog();
    chk("R1 pc in reset", pc_o, 32'h0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 pc after 3 cycles", pc_o, 32'd12);
    @(negedge clk);
    chk("R2 pc after 4 cycles", pc_o, 32'd16);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 pc cleared", pc_o, 32'h0);
  endtask

  task automatic t_lw();
    clear_prog();
    prog[0] = ld_w(16, 0, 1);
    prog[1] = ld_w(4, 1, 2);
    load_prog();
    rst = 1'b0;
    #1;
    chk("R3 lw dec_wen2", {31'b0, dec_wen2}, 32'h0);
    chk("R3 lw dec_wen1", {31'b0, dec_wen1}, 32'h1);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk_reg("R3 lw base unchanged", 1, 32'h10);
    chk_reg("R3 R10 lw dependent load", 2, 32'hA000_0005);
  endtask

  task automatic t_linc();
    clear_prog();
    prog[0] = ld_w(16, 0, 3);
    prog[1] = li_w(0, 3, 4);
    prog[2] = li_w(0, 3, 5);
    load_prog();
    rst = 1'b0;
    @(negedge clk);
    chk("R4 dec_wen2", {31'b0, dec_wen2}, 32'h1);
    chk("R4 dec_wen1", {31'b0, dec_wen1}, 32'h1);
    chk("R4 dec_mrd", {31'b0, dec_mrd}, 32'h1);
    chk("R4 dec_mwe", {31'b0, dec_mwe}, 32'h0);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk_reg("R4 base twice incremented", 3, 32'h18);
    chk_reg("R4 first load", 4, 32'h10);
    chk_reg("R4 R10 second load uses incremented base", 5, 32'hA000_0005);
  endtask

  task automatic t_neg();
    clear_prog();
    prog[0] = ld_w(32, 0, 6);
    prog[1] = li_w(-8, 6, 7);
    load_prog();
    run(2);
    chk_reg("R5 negative offset data", 7, 32'hA000_0006);
    chk_reg("R5 base incremented", 6, 32'h24);
  endtask

  task automatic t_same();
    clear_prog();
    prog[0] = ld_w(32, 0, 8);
    prog[1] = li_w(4, 8, 8);
    load_prog();
    run(2);
    chk_reg("R6 load wins on rd==rs1", 8, 32'hA000_0009);
  endtask

  task automatic t_x0();
    clear_prog();
    prog[0] = ld_w(16, 0, 9);
    prog[1] = li_w(0, 9, 0);
    prog[2] = li_w(8, 0, 10);
    prog[3] = ld_w(4, 0, 0);
    load_prog();
    run(4);
    chk_reg("R7 x0 stays zero", 0, 32'h0);
    chk_reg("R7 increment with rd=x0", 9, 32'h14);
    chk_reg("R7 load with rs1=x0", 10, 32'hA000_0002);
  endtask

  task automatic t_align();
    clear_prog();
    prog[0] = ld_w(5, 0, 11);
    prog[1] = ld_w(19, 0, 12);
    load_prog();
    run(2);
    chk_reg("R8 offset 5 -> word 1", 11, 32'hA000_0001);
    chk_reg("R8 offset 19 -> word 4", 12, 32'h10);
  endtask

  task automatic t_bad();
    clear_prog();
    prog[0] = ld_w(4, 0, 13);
    prog[1] = {12'd8, 5'd13, 3'b000, 5'd13, 7'b0110011};
    prog[2] = {12'd8, 5'd13, 3'b000, 5'd13, 7'b0001011};
    prog[3] = {12'd8, 5'd13, 3'b011, 5'd13, 7'b0000011};
    load_prog();
    rst = 1'b0;
    @(negedge clk);
    chk("R9 unknown opcode enables", {28'b0, dec_wen1, dec_wen2, dec_mrd, dec_mwe}, 32'h0);
    @(negedge clk);
    chk("R9 bad funct3 inc enables", {28'b0, dec_wen1, dec_wen2, dec_mrd, dec_mwe}, 32'h0);
    @(negedge clk);
    chk("R9 bad funct3 load enables", {28'b0, dec_wen1, dec_wen2, dec_mrd, dec_mwe}, 32'h0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk_reg("R9 register untouched", 13, 32'hA000_0001);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    load_data();
    t_pc();
    t_lw();
    t_linc();
    t_neg();
    t_same();
    t_x0();
    t_align();
    t_bad();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule